// File: doc/BRIEF.md
# Two-Level Multi-CPU Interrupt Controller

This block collects level-sensitive interrupt sources and delivers them to up to four CPUs. Each source passes through two gates before it reaches a CPU. The first is a single enable bit that all CPUs share. The second is a set of routing bits, one bit per CPU. A source reaches CPU `c` only when three things are true: the source is asserted, it is enabled, and its routing bit `c` is set. Each CPU's IRQ output is the OR of every source that reaches that CPU.

Software sets and clears the enable and routing bits by writing a source number to separate set and clear registers. It does not do read-modify-write on bitmaps. Each source also has its own control word, through which all of its routing bits can be read or written at once.

The block has one register port, which carries a CPU identifier. Addresses with bit 11 set form a per-CPU window. Accesses there act on the registers of the CPU that makes the access. That window also holds an acknowledge register, which returns the lowest-numbered source that is pending for that CPU.

By convention, software treats sources 0 to 28 as per-CPU sources and leaves them enabled globally. Higher numbers are shared sources, which software steers with their routing bits. Source 0 carries the inter-processor doorbell summary and source 1 the message-signalled doorbell summary. The hardware gates every source the same way.

The port has no back-pressure. There is no ready signal: every request is taken in the cycle it is presented. Read data comes back exactly one cycle later with `rsp_valid`, and the requester cannot stall it.

Top module: `dual_gate_intc`

## Requirements
- R1: A read of global offset 0x000 returns the number of implemented sources in bits [11:2] and zero in every other bit.
- R2: Writing source number n to global offset 0x030 sets the enable of source n, and writing it to 0x034 clears that enable. A number of NUM_SRC or more is ignored and does not alias to a lower source.
- R3: Writing source number n to per-CPU offset 0x848 clears routing bit `req_cpu` of source n, and writing it to 0x84C sets that bit. No other CPU's bit changes, and a number of NUM_SRC or more is ignored.
- R4: The control word of source n sits at global offset 0x100 + 4n. Bits [NUM_CPU-1:0] hold its routing bits (bit c routes to CPU c) and can be read and written. Every other bit reads as zero and ignores writes.
- R5: `irq_out[c]` is high exactly when some source is asserted, enabled, and routed to CPU c. It follows source and register changes with no added register stage.
- R6: A read of per-CPU offset 0x844 returns, in bits [9:0], the lowest source number deliverable to CPU `req_cpu` in the request cycle. If no source is deliverable it returns 1023. The read changes no state.
- R7: After reset every enable and routing bit is zero, every `irq_out` bit is low, and `rsp_valid` is low.
- R8: A read request produces `rsp_valid` with its data in the following cycle. A write produces no response. Unmapped or misaligned addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Level-sensitive source inputs |
| req_valid | input | 1 | Register request present, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W | Identifier of the CPU making the access |
| req_addr | input | ADDR_W | Byte address; bit 11 selects the per-CPU window |
| req_wdata | input | 32 | Write data or source number |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | NUM_CPU | Per-CPU interrupt request |

## Verification
An acknowledge read can fall in the same cycle as a change on a source input. Because the port has a single request path, no register write can coincide with such a read, so this is the case that matters. The bench drives the source edge and the read request at the same falling clock edge. It expects the returned number to reflect the source level that was presented during the request cycle: 1023 when the only deliverable source drops, and that source's number when it rises. A further check confirms that a repeated acknowledge read returns the same number, which shows that the read has no side effect.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Byte offsets inside each window (bit 11 of the address selects the window)
  localparam int INFO_OFS    = 'h000;
  localparam int EN_SET_OFS  = 'h030;
  localparam int EN_CLR_OFS  = 'h034;
  localparam int ROUTE_BASE  = 'h100;
  localparam int ACK_OFS     = 'h044;
  localparam int MSK_SET_OFS = 'h048;
  localparam int MSK_CLR_OFS = 'h04C;
  localparam int NONE_CODE   = 1023;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_INFO,
    RD_ROUTE,
    RD_ACK
  } rd_kind_e;
endpackage

// File: rtl/intc_regdec.sv
module intc_regdec
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              en_set,
  output logic              en_clr,
  output logic              msk_set,
  output logic              msk_clr,
  output logic              route_wr,
  output logic              num_ok,
  output logic [IDX_W-1:0]  num_idx,
  output logic [IDX_W-1:0]  route_idx,
  output logic              rd_go,
  output rd_kind_e          rd_kind
);
  logic              glb;
  logic              wr;
  logic              in_route;
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] rel;

  assign glb = ~req_addr[ADDR_W-1];
  assign off = {1'b0, req_addr[ADDR_W-2:0]};
  assign rel = off - ADDR_W'(ROUTE_BASE);
  assign wr  = req_valid & req_write;

  assign in_route = glb && (off >= ADDR_W'(ROUTE_BASE)) && (rel[1:0] == 2'b00)
                    && ((rel >> 2) < ADDR_W'(NUM_SRC));

  assign num_ok    = req_wdata < 32'(NUM_SRC);
  assign num_idx   = req_wdata[IDX_W-1:0];
  assign route_idx = rel[IDX_W+1:2];

  assign en_set   = wr &  glb & (off == ADDR_W'(EN_SET_OFS));
  assign en_clr   = wr &  glb & (off == ADDR_W'(EN_CLR_OFS));
  assign msk_set  = wr & ~glb & (off == ADDR_W'(MSK_SET_OFS));
  assign msk_clr  = wr & ~glb & (off == ADDR_W'(MSK_CLR_OFS));
  assign route_wr = wr & in_route;
  assign rd_go    = req_valid & ~req_write;

  always_comb begin
    if (glb && off == ADDR_W'(INFO_OFS))      rd_kind = RD_INFO;
    else if (in_route)                        rd_kind = RD_ROUTE;
    else if (!glb && off == ADDR_W'(ACK_OFS)) rd_kind = RD_ACK;
    else                                      rd_kind = RD_NONE;
  end
endmodule

// File: rtl/intc_gate_store.sv
module intc_gate_store #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            en_set,
  input  logic                            en_clr,
  input  logic                            msk_set,
  input  logic                            msk_clr,
  input  logic                            num_ok,
  input  logic [IDX_W-1:0]                num_idx,
  input  logic [CPU_W-1:0]                cpu,
  input  logic                            route_wr,
  input  logic [IDX_W-1:0]                route_idx,
  input  logic [NUM_CPU-1:0]              route_wdata,
  output logic [NUM_SRC-1:0]              enable_q,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q
);
  logic cpu_ok;

  generate
    if (NUM_CPU == (1 << CPU_W)) begin : g_full_cpu
      assign cpu_ok = 1'b1;
    end else begin : g_part_cpu
      assign cpu_ok = int'(cpu) < NUM_CPU;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      route_q  <= '0;
    end else begin
      if (num_ok && en_set) enable_q[num_idx] <= 1'b1;
      if (num_ok && en_clr) enable_q[num_idx] <= 1'b0;
      if (num_ok && cpu_ok && msk_set) route_q[num_idx][cpu] <= 1'b0;
      if (num_ok && cpu_ok && msk_clr) route_q[num_idx][cpu] <= 1'b1;
      if (route_wr) route_q[route_idx] <= route_wdata;
    end
  end
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int NUM_SRC = 64,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] hits,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  // Scan from the top so the lowest set bit is the last one written
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hits[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dual_gate_intc.sv
module dual_gate_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [CPU_W-1:0]   req_cpu,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic [NUM_CPU-1:0] irq_out
);
  logic                            en_set, en_clr, msk_set, msk_clr, route_wr;
  logic                            num_ok, rd_go;
  logic [IDX_W-1:0]                num_idx, route_idx;
  rd_kind_e                        rd_kind;
  logic [NUM_SRC-1:0]              enable_q;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] live;
  logic [NUM_CPU-1:0]              any_hit;
  logic [NUM_CPU-1:0][IDX_W-1:0]   low_idx;
  logic [31:0]                     ack_val;
  logic [31:0]                     rd_val;

  intc_regdec #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .en_set    (en_set),
    .en_clr    (en_clr),
    .msk_set   (msk_set),
    .msk_clr   (msk_clr),
    .route_wr  (route_wr),
    .num_ok    (num_ok),
    .num_idx   (num_idx),
    .route_idx (route_idx),
    .rd_go     (rd_go),
    .rd_kind   (rd_kind)
  );

  intc_gate_store #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_set      (en_set),
    .en_clr      (en_clr),
    .msk_set     (msk_set),
    .msk_clr     (msk_clr),
    .num_ok      (num_ok),
    .num_idx     (num_idx),
    .cpu         (req_cpu),
    .route_wr    (route_wr),
    .route_idx   (route_idx),
    .route_wdata (req_wdata[NUM_CPU-1:0]),
    .enable_q    (enable_q),
    .route_q     (route_q)
  );

  // One deliverable vector and one lowest-source encoder per CPU
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      assign live[c][n] = src_in[n] & enable_q[n] & route_q[n][c];
    end
    intc_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .hits  (live[c]),
      .found (any_hit[c]),
      .idx   (low_idx[c])
    );
  end

  assign irq_out = any_hit;
  assign ack_val = any_hit[req_cpu] ? 32'(low_idx[req_cpu]) : 32'(NONE_CODE);

  always_comb begin
    unique case (rd_kind)
      RD_INFO:  rd_val = {20'd0, 10'(NUM_SRC), 2'd0};
      RD_ROUTE: rd_val = 32'(route_q[route_idx]);
      RD_ACK:   rd_val = ack_val;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) rsp_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/dual_gate_intc_chk.sv
module dual_gate_intc_chk
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_SRC-1:0]              src_in,
  input logic                            req_valid,
  input logic                            req_write,
  input logic [CPU_W-1:0]                req_cpu,
  input logic [ADDR_W-1:0]               req_addr,
  input logic [31:0]                     req_wdata,
  input logic                            rsp_valid,
  input logic [9:0]                      ack_field,
  input logic [NUM_CPU-1:0]              irq_out,
  input logic [NUM_SRC-1:0]              enable_q,
  input logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q
);
  localparam logic [ADDR_W-1:0] EN_CLR_A  = ADDR_W'(EN_CLR_OFS);
  localparam logic [ADDR_W-1:0] MSK_SET_A = {1'b1, (ADDR_W-1)'(MSK_SET_OFS)};
  localparam logic [ADDR_W-1:0] ACK_A     = {1'b1, (ADDR_W-1)'(ACK_OFS)};

  assert_reset_quiet_R7: assert property (@(posedge clk)
    !rst_n |=> irq_out == '0);

  assert_clear_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_addr == EN_CLR_A && req_wdata < 32'(NUM_SRC)
    |=> !enable_q[$past(req_wdata[IDX_W-1:0])]);

  assert_mask_own_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_addr == MSK_SET_A && req_wdata < 32'(NUM_SRC)
    |=> !route_q[$past(req_wdata[IDX_W-1:0])][$past(req_cpu)]);

  assert_irq_needs_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    |irq_out |-> |(src_in & enable_q));

  assert_ack_number_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(req_addr) == ACK_A && ack_field != 10'(NONE_CODE)
    |-> $past(irq_out[req_cpu]));

  assert_ack_none_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(req_addr) == ACK_A && ack_field == 10'(NONE_CODE)
    |-> !$past(irq_out[req_cpu]));

  assert_resp_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
endmodule

bind dual_gate_intc dual_gate_intc_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_in    (src_in),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_cpu   (req_cpu),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .ack_field (rsp_rdata[9:0]),
  .irq_out   (irq_out),
  .enable_q  (enable_q),
  .route_q   (route_q)
);

// File: tb/dual_gate_intc_bench.sv
module dual_gate_intc_bench;
  localparam int NS = 64;
  localparam int NC = 4;

  localparam int OP_WR = 0, OP_RD = 1, OP_SON = 2, OP_SOFF = 3, OP_IRQ = 4;

  // {op[3:0], cpu[3:0], tag[3:0], addr[11:0], data[31:0], expect[31:0]}
  function automatic logic [87:0] mk(int op, int cpu, int tag, int addr, int data, int exp);
    return {op[3:0], cpu[3:0], tag[3:0], addr[11:0], data[31:0], exp[31:0]};
  endfunction

  localparam int NV = 42;
  localparam logic [87:0] VEC [NV] = '{
    mk(OP_RD,  0, 1, 'h000, 0,     'h100), // R1 info word
    mk(OP_RD,  0, 6, 'h844, 0,     1023),  // R6 nothing pending
    mk(OP_SON, 0, 5, 0,     40,    0),
    mk(OP_IRQ, 0, 5, 0,     0,     0),     // R5 not enabled
    mk(OP_WR,  0, 2, 'h030, 40,    0),     // R2 enable 40
    mk(OP_IRQ, 0, 5, 0,     0,     0),     // R5 no routing yet
    mk(OP_WR,  0, 4, 'h1A0, 2,     0),     // R4 route 40 -> cpu1
    mk(OP_IRQ, 0, 5, 0,     0,     2),     // R5
    mk(OP_RD,  1, 6, 'h844, 0,     40),    // R6
    mk(OP_RD,  0, 6, 'h844, 0,     1023),  // R6 other cpu
    mk(OP_SON, 0, 5, 0,     5,     0),
    mk(OP_WR,  0, 2, 'h030, 5,     0),     // R2
    mk(OP_WR,  2, 3, 'h84C, 5,     0),     // R3 cpu2 unmask 5
    mk(OP_IRQ, 0, 5, 0,     0,     6),     // R5
    mk(OP_RD,  0, 3, 'h114, 0,     4),     // R3 only cpu2 bit
    mk(OP_WR,  1, 3, 'h84C, 5,     0),     // R3 cpu1 unmask 5
    mk(OP_RD,  0, 3, 'h114, 0,     6),     // R3
    mk(OP_RD,  1, 6, 'h844, 0,     5),     // R6 lowest of 5 and 40
    mk(OP_WR,  1, 3, 'h848, 40,    0),     // R3 cpu1 mask 40
    mk(OP_RD,  0, 3, 'h1A0, 0,     0),     // R3
    mk(OP_IRQ, 0, 5, 0,     0,     6),     // R5
    mk(OP_WR,  1, 3, 'h848, 69,    0),     // R3 out of range, no alias to 5
    mk(OP_RD,  0, 3, 'h114, 0,     6),     // R3
    mk(OP_WR,  0, 2, 'h034, 5,     0),     // R2 disable 5
    mk(OP_IRQ, 0, 2, 0,     0,     0),     // R2
    mk(OP_RD,  2, 6, 'h844, 0,     1023),  // R6
    mk(OP_WR,  0, 4, 'h1A0, 'hF09, 0),     // R4 upper bits dropped
    mk(OP_RD,  0, 4, 'h1A0, 0,     9),     // R4
    mk(OP_IRQ, 0, 5, 0,     0,     9),     // R5
    mk(OP_RD,  3, 6, 'h844, 0,     40),    // R6
    mk(OP_RD,  3, 6, 'h844, 0,     40),    // R6 read has no side effect
    mk(OP_WR,  0, 2, 'h034, 40,    0),     // R2
    mk(OP_IRQ, 0, 2, 0,     0,     0),     // R2
    mk(OP_WR,  0, 2, 'h030, 104,   0),     // R2 out of range, no alias to 40
    mk(OP_IRQ, 0, 2, 0,     0,     0),     // R2
    mk(OP_WR,  0, 2, 'h030, 40,    0),     // R2
    mk(OP_IRQ, 0, 5, 0,     0,     9),     // R5
    mk(OP_RD,  0, 8, 'h200, 0,     0),     // R8 past last source word
    mk(OP_RD,  0, 8, 'h1A1, 0,     0),     // R8 misaligned
    mk(OP_SOFF,0, 5, 0,     40,    0),
    mk(OP_IRQ, 0, 5, 0,     0,     0),     // R5
    mk(OP_RD,  0, 6, 'h844, 0,     1023)   // R6
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_in = '0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [1:0]    req_cpu = '0;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [NC-1:0] irq_out;

  int n_chk = 0;
  int n_bad = 0;
  logic got_valid;

  always #2 clk = ~clk;

  dual_gate_intc u_dual_gate_intc (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .req_valid(req_valid), .req_write(req_write), .req_cpu(req_cpu),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_out(irq_out)
  );

  task automatic chk(input int tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input int cpu, input int addr, input int data,
                     output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cpu = cpu[1:0];
    req_addr = addr[11:0]; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd = rsp_rdata;
    got_valid = rsp_valid;
  endtask

  task automatic run_table();
    logic [87:0] v;
    logic [31:0] rd;
    int op, cpu, tag, addr, data, exp;
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      op = int'(v[87:84]); cpu = int'(v[83:80]); tag = int'(v[79:76]);
      addr = int'(v[75:64]); data = int'(v[63:32]); exp = int'(v[31:0]);
      case (op)
        OP_WR: bus(1'b1, cpu, addr, data, rd);
        OP_RD: begin
          bus(1'b0, cpu, addr, data, rd);
          chk(8, 32'(got_valid), 1);  // R8 response one cycle later
          chk(tag, rd, exp);
        end
        OP_SON:  begin @(negedge clk); src_in[data] = 1'b1; end
        OP_SOFF: begin @(negedge clk); src_in[data] = 1'b0; end
        default: begin @(negedge clk); chk(tag, 32'(irq_out), exp); end
      endcase
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R0: watchdog expired, actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(7, 32'(irq_out), 0);
    chk(7, 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_table();

    // R8 a write gives no response
    bus(1'b1, 0, 'h030, 3, rd);
    chk(8, 32'(got_valid), 0);

    // R6 source edge in the same cycle as the acknowledge read
    bus(1'b1, 0, 'h10C, 1, rd);           // route source 3 to cpu0
    @(negedge clk); src_in[3] = 1'b1;
    @(negedge clk); chk(5, 32'(irq_out), 1);
    @(negedge clk);
    src_in[3] = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_cpu = 2'd0; req_addr = 12'h844;
    @(negedge clk);
    req_valid = 1'b0;
    chk(6, rsp_rdata, 1023);              // R6 falling source seen at once
    src_in[3] = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(6, rsp_rdata, 3);                 // R6 rising source seen at once

    // R7 reset mid-run clears enables and routing
    src_in[40] = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk(7, 32'(irq_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(7, 32'(irq_out), 0);
    bus(1'b0, 0, 'h10C, 0, rd);
    chk(7, rd, 0);
    bus(1'b0, 0, 'h844, 0, rd);
    chk(7, rd, 1023);
    bus(1'b1, 0, 'h030, 40, rd);          // enable alone is not enough
    @(negedge clk);
    chk(7, 32'(irq_out), 0);
    bus(1'b0, 0, 'h000, 0, rd);
    chk(1, rd, 'h100);                    // R1 after reset

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule